// File: doc/BRIEF.md
# PLL lock status monitor

This block judges whether a clock-recovery loop has locked. On every edge of a reference sample clock it takes one sample of a phase indicator bit that comes from the recovered clock. It turns that sample stream into an active-low lock flag. Lock and unlock use different rules, so the flag has hysteresis. An unbroken run of low samples declares lock. Unlock needs persistent trouble: a number of consecutive fixed-length frames that each hold too many high samples.

When the flag leaves the locked state, the block raises a recalibration request for one cycle so that the calibration logic starts again. A loss-of-signal input aborts all counting while it is high. When that input is removed and the loop is still unlocked, the block issues a fresh recalibration request. The defaults are a 32-sample lock run, 256-sample frames, a limit of 5 hits per frame and a streak of 5 bad frames. All four are parameters.

Top module: `pll_lock_watch`

## Requirements
- R1: While `rst_ni` is low, `lock_n_o` is 1 (unlocked) and `recal_o` is 0, whatever the other inputs do.
- R2: `lock_n_o` becomes 0 after the clock edge that samples `phase_hi_i` low for the 32nd consecutive time. A high sample restarts the run, so 31 lows followed by a high do not lock.
- R3: Samples are grouped into frames of 256. The first frame starts with the first sample taken after reset or after loss of signal is removed. A frame is bad when more than 5 of its samples are high, so exactly 5 high samples make a good frame.
- R4: `lock_n_o` becomes 1 after the edge that ends the 5th consecutive bad frame. A good frame restarts the streak.
- R5: A sample that completes neither the lock condition nor the unlock condition leaves `lock_n_o` unchanged.
- R6: When one sample completes both the lock run and the unlock streak, unlock wins and `lock_n_o` becomes 1.
- R7: `recal_o` is 1 for exactly one cycle: the first cycle in which `lock_n_o` is 1 after being 0.
- R8: While `sig_lost_i` is 1, the run, frame and streak counts are held at zero and `lock_n_o` keeps its value. Counting restarts from the first sample taken with `sig_lost_i` low.
- R9: If `lock_n_o` is 1 at the edge that first samples `sig_lost_i` low after it was high, `recal_o` is 1 for the following cycle. If the block is locked at that edge, no request is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_hi_i | input | 1 | Sampled recovered-clock phase indicator |
| sig_lost_i | input | 1 | Loss of signal, active high |
| lock_n_o | output | 1 | Lock flag, 0 = locked, 1 = unlocked |
| recal_o | output | 1 | One-cycle recalibration request |

## Verification
The hardest situations to reach from the ports depend on where the frame boundaries fall. These are the good frame that breaks a streak of four bad ones, and the sample on which the unlock streak completes while the last 32 samples are all low (R6). The bench pulses loss of signal once to put the frame boundary at a known sample. It then drives blocks that repeat every 256 cycles. Each block holds a cluster of high samples at its start followed by a long low tail. The final sample of the fifth bad block therefore closes the streak and the lock run at the same moment. The next sample re-locks, which exposes a recalibration pulse lasting one cycle.

// File: rtl/lockwatch_pkg.sv
`timescale 1ns/1ps
package lockwatch_pkg;

   // width of a counter that must hold the values 0..max_val
   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

   // width of an index that runs 0..depth-1
   function automatic int idx_width(input int depth);
      return (depth < 3) ? 1 : $clog2(depth);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   typedef enum logic [1:0] {
      EVT_NONE   = 2'd0,
      EVT_LOCK   = 2'd1,
      EVT_UNLOCK = 2'd2
   } lock_evt_e;

endpackage

// File: rtl/lw_run_detect.sv
`timescale 1ns/1ps
module lw_run_detect
   import lockwatch_pkg::*;
#(
   parameter int LOCK_RUN = 32
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic phase_hi_i,
   output logic lock_evt_o
);

   localparam int RUN_W = cnt_width(LOCK_RUN);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
   localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_RUN);

   generate
      if (LOCK_RUN < 1) begin : g_bad_run
         $error("lw_run_detect: LOCK_RUN must be at least 1");
      end
   endgenerate

   logic [RUN_W-1:0] run_q;

   // this sample is low and completes the required run
   assign lock_evt_o = !clr_i && !phase_hi_i && (run_q >= RUN_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= '0;
      end else if (clr_i || phase_hi_i) begin
         run_q <= '0;
      end else if (run_q != RUN_FULL) begin
         run_q <= run_q + 1'b1;
      end
   end

   // R2
   run_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_hi_i || clr_i) |=> (run_q == '0));

   // R2
   run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(run_q) <= LOCK_RUN));

endmodule

// File: rtl/lw_frame_count.sv
`timescale 1ns/1ps
module lw_frame_count
   import lockwatch_pkg::*;
#(
   parameter int FRAME_LEN = 256,
   parameter int HIT_LIMIT = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic phase_hi_i,
   output logic frame_end_o,
   output logic frame_bad_o
);

   localparam int POS_W = idx_width(FRAME_LEN);
   localparam int HIT_W = cnt_width(FRAME_LEN);
   localparam logic [HIT_W:0] HIT_MAX = (HIT_W + 1)'(HIT_LIMIT);

   generate
      if (FRAME_LEN < 2) begin : g_bad_len
         $error("lw_frame_count: FRAME_LEN must be at least 2");
      end
      if (HIT_LIMIT < 0 || HIT_LIMIT >= FRAME_LEN) begin : g_bad_lim
         $error("lw_frame_count: HIT_LIMIT must lie in 0..FRAME_LEN-1");
      end
   endgenerate

   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] pos_nxt;
   logic             pos_wrap;
   logic [HIT_W-1:0] hit_q;
   logic [HIT_W:0]   hit_total;

   // two ways to find the end of a frame, chosen by the frame length
   generate
      if (is_pow2(FRAME_LEN)) begin : g_pow2
         assign pos_wrap = &pos_q;
         assign pos_nxt  = pos_q + 1'b1;
      end else begin : g_cmp
         assign pos_wrap = (pos_q == POS_W'(FRAME_LEN - 1));
         assign pos_nxt  = pos_wrap ? '0 : pos_q + 1'b1;
      end
   endgenerate

   assign hit_total   = {1'b0, hit_q} + {{HIT_W{1'b0}}, phase_hi_i};
   assign frame_end_o = !clr_i && pos_wrap;
   assign frame_bad_o = (hit_total > HIT_MAX);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pos_q <= '0;
         hit_q <= '0;
      end else if (clr_i) begin
         pos_q <= '0;
         hit_q <= '0;
      end else begin
         pos_q <= pos_nxt;
         hit_q <= pos_wrap ? '0 : hit_total[HIT_W-1:0];
      end
   end

   // R3
   frame_hits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(hit_q) <= 32'(pos_q)));

   // R3
   frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_end_o |=> (pos_q == '0) && (hit_q == '0));

   // R8
   frame_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (pos_q == '0));

endmodule

// File: rtl/lw_streak.sv
`timescale 1ns/1ps
module lw_streak
   import lockwatch_pkg::*;
#(
   parameter int BAD_FRAMES = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic frame_end_i,
   input  logic frame_bad_i,
   output logic unlock_evt_o
);

   localparam int STR_W = cnt_width(BAD_FRAMES);

   generate
      if (BAD_FRAMES < 1) begin : g_bad_cnt
         $error("lw_streak: BAD_FRAMES must be at least 1");
      end
   endgenerate

   logic [STR_W-1:0] streak_q;

   generate
      if (BAD_FRAMES == 1) begin : g_single
         // every bad frame unlocks at once; no history is kept
         assign streak_q     = '0;
         assign unlock_evt_o = frame_end_i && frame_bad_i;
      end else begin : g_count
         localparam logic [STR_W-1:0] STR_LAST = STR_W'(BAD_FRAMES - 1);

         assign unlock_evt_o = frame_end_i && frame_bad_i && (streak_q == STR_LAST);

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               streak_q <= '0;
            end else if (clr_i) begin
               streak_q <= '0;
            end else if (frame_end_i) begin
               if (!frame_bad_i || unlock_evt_o) begin
                  streak_q <= '0;
               end else begin
                  streak_q <= streak_q + 1'b1;
               end
            end
         end
      end
   endgenerate

   // R4
   streak_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(streak_q) < BAD_FRAMES));

   // R4
   streak_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_end_i && !frame_bad_i) |=> (streak_q == '0));

endmodule

// File: rtl/pll_lock_watch.sv
`timescale 1ns/1ps
module pll_lock_watch
   import lockwatch_pkg::*;
#(
   parameter int LOCK_RUN   = 32,
   parameter int FRAME_LEN  = 256,
   parameter int HIT_LIMIT  = 5,
   parameter int BAD_FRAMES = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic phase_hi_i,
   input  logic sig_lost_i,
   output logic lock_n_o,
   output logic recal_o
);

   logic      lock_evt;
   logic      frame_end;
   logic      frame_bad;
   logic      unlock_evt;
   lock_evt_e evt;
   logic      lock_n_q;
   logic      recal_q;
   logic      lost_d_q;

   lw_run_detect #(
      .LOCK_RUN   (LOCK_RUN)
   ) u_run (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (sig_lost_i),
      .phase_hi_i (phase_hi_i),
      .lock_evt_o (lock_evt)
   );

   lw_frame_count #(
      .FRAME_LEN   (FRAME_LEN),
      .HIT_LIMIT   (HIT_LIMIT)
   ) u_frame (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (sig_lost_i),
      .phase_hi_i  (phase_hi_i),
      .frame_end_o (frame_end),
      .frame_bad_o (frame_bad)
   );

   lw_streak #(
      .BAD_FRAMES   (BAD_FRAMES)
   ) u_streak (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (sig_lost_i),
      .frame_end_i  (frame_end),
      .frame_bad_i  (frame_bad),
      .unlock_evt_o (unlock_evt)
   );

   // unlock takes precedence over lock on the same sample
   always_comb begin
      evt = EVT_NONE;
      if (unlock_evt) begin
         evt = EVT_UNLOCK;
      end else if (lock_evt) begin
         evt = EVT_LOCK;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lock_n_q <= 1'b1;
         recal_q  <= 1'b0;
         lost_d_q <= 1'b0;
      end else begin
         case (evt)
            EVT_UNLOCK: lock_n_q <= 1'b1;
            EVT_LOCK:   lock_n_q <= 1'b0;
            default:    lock_n_q <= lock_n_q;
         endcase
         recal_q  <= ((evt == EVT_UNLOCK) && !lock_n_q) ||
                     (lost_d_q && !sig_lost_i && lock_n_q);
         lost_d_q <= sig_lost_i;
      end
   end

   assign lock_n_o = lock_n_q;
   assign recal_o  = recal_q;

   // R7
   recal_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      recal_o |=> !recal_o);

   // R7
   recal_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      recal_o |-> lock_n_o);

   // R2
   lock_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(lock_n_o) |-> $past(!phase_hi_i && !sig_lost_i));

   // R8
   los_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sig_lost_i |=> $stable(lock_n_o));

endmodule

// File: tb/pll_lock_watch_bench.sv
`timescale 1ns/1ps
module pll_lock_watch_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hi = 1'b0;
   logic los = 1'b0;
   logic lock_n;
   logic recal;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string tag = "R1";

   // behavioural reference state
   bit hist[$];
   bit verd[$];
   int fpos;
   int fhits;
   bit m_lockn = 1'b1;
   bit m_recal = 1'b0;
   bit m_losp = 1'b0;

   always #2.5 clk = ~clk;

   pll_lock_watch u_pll_lock_watch (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .phase_hi_i (hi),
      .sig_lost_i (los),
      .lock_n_o   (lock_n),
      .recal_o    (recal)
   );

   task automatic model_tick();
      bit old_l;
      bit nrec;
      bit unl;
      bit lk;
      bit all_bad;
      if (!rst_n) begin
         hist.delete(); verd.delete();
         fpos = 0; fhits = 0;
         m_lockn = 1'b1; m_recal = 1'b0; m_losp = 1'b0;
         return;
      end
      old_l = m_lockn; nrec = 1'b0; unl = 1'b0; lk = 1'b0;
      if (los) begin
         hist.delete(); verd.delete();
         fpos = 0; fhits = 0;
      end else begin
         hist.push_back(hi);
         if (hist.size() > 32) void'(hist.pop_front());
         fhits += int'(hi);
         if (fpos == 255) begin
            verd.push_back(fhits > 5);
            if (verd.size() > 5) void'(verd.pop_front());
            fpos = 0; fhits = 0;
            all_bad = (verd.size() == 5);
            foreach (verd[i]) if (!verd[i]) all_bad = 1'b0;
            if (all_bad) begin
               unl = 1'b1;
               verd.delete();
            end
         end else begin
            fpos++;
         end
         if (hist.size() == 32) begin
            lk = 1'b1;
            foreach (hist[i]) if (hist[i]) lk = 1'b0;
         end
      end
      if (unl) begin
         if (!old_l) nrec = 1'b1;
         m_lockn = 1'b1;
      end else if (lk) begin
         m_lockn = 1'b0;
      end
      if (m_losp && !los && old_l) nrec = 1'b1;
      m_losp = los;
      m_recal = nrec;
   endtask

   task automatic chk(input string t, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", t, what, act, exp, $time);
      end
   endtask

   // one sample: drive away from the edge, update the model at the edge, compare after it
   task automatic step(input logic h, input logic l);
      @(negedge clk);
      hi = h;
      los = l;
      @(posedge clk);
      model_tick();
      #1;
      chk(tag, lock_n, m_lockn, "lock_n_o vs model");
      chk(tag, recal, m_recal, "recal_o vs model");
   endtask

   task automatic lows(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0);
   endtask

   // one 256-sample block: nh highs at its start, then lows
   task automatic block(input int nh);
      for (int i = 0; i < 256; i++) step(i < nh, 1'b0);
   endtask

   initial begin
      int seen_hi;
      int seen_rec;

      // R1: reset holds the flag high even under a long low run
      tag = "R1";
      rst_n = 1'b0;
      for (int i = 0; i < 40; i++) step(1'b0, 1'b0);
      chk("R1", lock_n, 1'b1, "unlocked in reset");
      chk("R1", recal, 1'b0, "no request in reset");
      rst_n = 1'b1;

      // R2: 31 lows then a high do not lock; 32 lows do
      tag = "R2";
      lows(31);
      chk("R2", lock_n, 1'b1, "31 lows not enough");
      step(1'b1, 1'b0);
      lows(31);
      chk("R2", lock_n, 1'b1, "run restarted by high");
      lows(1);
      chk("R2", lock_n, 1'b0, "locked on 32nd low");

      // R9: loss of signal removed while locked gives no request
      tag = "R9";
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      chk("R9", recal, 1'b0, "no request when locked");

      // R3/R5: exactly 5 highs per frame keep the lock
      tag = "R3";
      seen_hi = 0;
      for (int b = 0; b < 8; b++) begin
         for (int i = 0; i < 256; i++) begin
            step(i < 5, 1'b0);
            if (lock_n !== 1'b0) seen_hi++;
         end
      end
      chk("R3", seen_hi == 0, 1'b1, "5-hit frames stayed locked");
      chk("R5", lock_n, 1'b0, "flag held");

      // R4: four bad, one good, four bad frames do not unlock (frame aligned by a loss pulse)
      tag = "R4";
      step(1'b0, 1'b1);
      seen_rec = 0;
      for (int b = 0; b < 9; b++) begin
         for (int i = 0; i < 256; i++) begin
            step((b != 4) && (i < 6), 1'b0);
            if (recal === 1'b1) seen_rec++;
         end
      end
      chk("R4", seen_rec == 0, 1'b1, "good frame broke streak");
      chk("R4", lock_n, 1'b0, "still locked after broken streak");

      // R4/R6/R7: fifth consecutive bad frame unlocks while the low run is also complete
      tag = "R6";
      for (int i = 0; i < 255; i++) step(i < 6, 1'b0);
      chk("R4", lock_n, 1'b0, "locked before frame end");
      step(1'b0, 1'b0);
      chk("R6", lock_n, 1'b1, "unlock wins over lock");
      chk("R7", recal, 1'b1, "request on unlock");
      step(1'b0, 1'b0);
      chk("R7", recal, 1'b0, "request lasts one cycle");
      chk("R2", lock_n, 1'b0, "relocked on next low");

      // R8/R9: loss while unlocked clears the run and requests on removal
      tag = "R8";
      rst_n = 1'b0;
      step(1'b0, 1'b0);
      rst_n = 1'b1;
      lows(20);
      step(1'b1, 1'b1);
      step(1'b0, 1'b1);
      chk("R8", lock_n, 1'b1, "flag held during loss");
      step(1'b0, 1'b0);
      chk("R9", recal, 1'b1, "request on loss removal while unlocked");
      lows(19);
      chk("R8", recal, 1'b0, "single request");
      chk("R8", lock_n, 1'b1, "run restarted after loss");
      lows(11);
      chk("R8", lock_n, 1'b1, "31 lows after loss");
      lows(1);
      chk("R8", lock_n, 1'b0, "locked 32 samples after loss");

      // R8: loss while locked holds the flag low
      step(1'b1, 1'b1);
      step(1'b1, 1'b1);
      chk("R8", lock_n, 1'b0, "locked flag held during loss");
      step(1'b0, 1'b0);
      chk("R9", recal, 1'b0, "no request when locked");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule